// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block moves a small processor core between normal execution and two low-power states, a light one (sleep) and a deep one (standby). A one-cycle sleep strobe from the core enters a low-power state. The level of a deep-select bit at that moment picks which one. In sleep only the CPU clock stops. In standby the CPU clock, the peripheral clocks and the oscillator all stop, and a one-cycle initialization pulse goes to the peripherals that must restart clean.

Each low-power state has its own wake sources. Sleep ends on an unmasked, enabled interrupt, a DMA address error or an NMI edge. Standby ends only on an NMI edge. Leaving standby is done in two steps: first the oscillator restarts and only the watchdog is clocked, then the whole chip is ungated once the watchdog reports overflow.

Power-on and manual reset requests override everything. Each exit from a low-power state or from reset raises a one-cycle exception request with a cause code, on the cycle in which the CPU clock enable rises.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: With `sleep_strobe` high and `deep_sel` low while running, the next cycle has `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R2: With `sleep_strobe` high and `deep_sel` high while running, the next cycle has `cpu_clk_en`, `per_clk_en`, `osc_en` and `wdt_clk_en` all 0. `per_init_pulse` is high for exactly that first standby cycle.
- R3: In sleep, an interrupt wakes the core only when `irq_valid` and `irq_src_en` are high and `irq_level` is strictly greater than `mask_level`. The core then runs on the next cycle with cause 5. A level equal to the mask, or a disabled source, leaves the core asleep.
- R4: In sleep, `dma_addr_err` wakes the core on the next cycle with cause 4. In standby, DMA errors and interrupts have no effect.
- R5: `nmi_pin` passes through a two-flop synchronizer. The wake edge is rising when `nmi_rise_sel`=1 and falling when it is 0, and the opposite edge is ignored. An NMI edge in sleep gives a run state with cause 3 on the third clock edge after the pin changes.
- R6: NMI edges detected during the 5 clock edges that follow the entry strobe are discarded and never held pending.
- R7: A valid NMI edge in standby enables `osc_en` and `wdt_clk_en` while `cpu_clk_en` and `per_clk_en` stay 0. On `wdt_ovf` the next cycle is run state with all enables 1 and cause 3.
- R8: `por_req` or `mrst_req` in any state holds `cpu_clk_en` at 0. The cycle after both are low, the core runs with cause 1 if a power-on request was seen during the hold, otherwise with cause 2.
- R9: Simultaneous wake events in sleep are ranked NMI, then DMA error, then interrupt.
- R10: `exc_req` is one cycle long and appears only on the cycle where `cpu_clk_en` rises. `exc_cause` is 0 whenever `exc_req` is low.
- R11: After `rst_n`, the block runs with all four enables at 1, and `exc_req` and `per_init_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_strobe | input | 1 | One-cycle sleep instruction strobe |
| deep_sel | input | 1 | 0 selects sleep, 1 selects standby |
| irq_valid | input | 1 | Interrupt request present |
| irq_src_en | input | 1 | Interrupt enabled at its source |
| irq_level | input | 4 | Interrupt priority |
| mask_level | input | 4 | Current mask level |
| dma_addr_err | input | 1 | DMA address error |
| nmi_pin | input | 1 | Asynchronous NMI pin |
| nmi_rise_sel | input | 1 | 1 rising, 0 falling NMI edge |
| por_req | input | 1 | Power-on reset request |
| mrst_req | input | 1 | Manual reset request |
| wdt_ovf | input | 1 | Settling watchdog overflow |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_init_pulse | output | 1 | Peripheral initialization pulse |
| osc_en | output | 1 | Oscillator enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| exc_req | output | 1 | Exception request pulse |
| exc_cause | output | 3 | Cause: 1 POR, 2 manual, 3 NMI, 4 DMA, 5 IRQ |

## Verification
The hardest case to reach is an NMI edge that arrives inside the 5-cycle blocking window after a standby entry. The edge has to get through both synchronizer flops and reach the edge detector while the window is still open. The stimulus sets the pin on the falling clock edge right after the entry strobe. The detected edge then lands on the third clock edge after entry, with the window counter still at 3. After that the bench checks that standby persists through later cycles, a bare opposite edge and DMA or interrupt activity. Only then does it give a fresh valid edge and check the watchdog handshake.

// File: rtl/lpm_pkg.sv
// Shared state and cause encodings for the low-power sequencer.
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_SLEEP   = 3'd1,
        ST_STANDBY = 3'd2,
        ST_WARMUP  = 3'd3,
        ST_RSTHOLD = 3'd4
    } lpm_state_e;

    localparam int CAUSE_W = 3;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE = 3'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_POR  = 3'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_MRST = 3'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_NMI  = 3'd3;
    localparam logic [CAUSE_W-1:0] CAUSE_DMA  = 3'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_IRQ  = 3'd5;
endpackage

// File: rtl/lpm_nmi_detect.sv
// NMI front end: synchronizes the pin, detects the selected edge and
// discards edges for BLOCK_CYC clock edges after a low-power entry.
// Assumes the pin is low (or stable) while rst_n is asserted.
module lpm_nmi_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int BLOCK_CYC   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic rise_sel,
    input  logic block_start,
    output logic nmi_ok
);
    localparam int CW = $clog2(BLOCK_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [CW-1:0]          blk_cnt;
    logic                   cur;
    logic                   edge_seen;

    // Shift the pin through the synchronizer chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Blocking window counter, reloaded on every low-power entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_cnt <= '0;
        else if (block_start)
            blk_cnt <= CW'(BLOCK_CYC);
        else if (blk_cnt != '0)
            blk_cnt <= blk_cnt - 1'b1;
    end

    // Selected edge, qualified by the closed window.
    always_comb begin
        cur       = sync_q[SYNC_STAGES-1];
        edge_seen = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);
        nmi_ok    = edge_seen && (blk_cnt == '0);
    end

    // R6: right after an entry the window is fully loaded.
    assert_window_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        block_start |=> (blk_cnt == CW'(BLOCK_CYC)));
endmodule

// File: rtl/lpm_wake_arb.sv
// Ranks wake events that apply in sleep: NMI, then DMA error, then an
// interrupt whose level strictly exceeds the mask. Purely combinational.
module lpm_wake_arb
    import lpm_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic               nmi_ok,
    input  logic               dma_err,
    input  logic               irq_valid,
    input  logic               irq_src_en,
    input  logic [LVL_W-1:0]   irq_level,
    input  logic [LVL_W-1:0]   mask_level,
    output logic               wake,
    output logic [CAUSE_W-1:0] cause
);
    logic irq_accept;

    // Fixed-priority selection of the sleep wake cause.
    always_comb begin
        irq_accept = irq_valid && irq_src_en && (irq_level > mask_level);
        wake  = 1'b1;
        cause = CAUSE_NONE;
        if (nmi_ok)          cause = CAUSE_NMI;
        else if (dma_err)    cause = CAUSE_DMA;
        else if (irq_accept) cause = CAUSE_IRQ;
        else                 wake  = 1'b0;
    end
endmodule

// File: rtl/lpm_seq_fsm.sv
// Mode sequencer: run, sleep, standby, watchdog warm-up and reset hold.
// Drives the clock enables as decodes of the state register and issues the
// registered exception pulse together with the CPU clock enable rising.
module lpm_seq_fsm
    import lpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_strobe,
    input  logic               deep_sel,
    input  logic               por_req,
    input  logic               mrst_req,
    input  logic               nmi_ok,
    input  logic               sleep_wake,
    input  logic [CAUSE_W-1:0] sleep_cause,
    input  logic               wdt_ovf,
    output logic               lp_entry,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               per_init_pulse,
    output logic               osc_en,
    output logic               wdt_clk_en,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause
);
    lpm_state_e         state, state_nx;
    logic               rst_any;
    logic               fire;
    logic [CAUSE_W-1:0] fire_cause;
    logic [CAUSE_W-1:0] rst_cause_q;

    // Next state and exit event; reset requests override every state.
    always_comb begin
        rst_any    = por_req || mrst_req;
        lp_entry   = (state == ST_RUN) && sleep_strobe && !rst_any;
        state_nx   = state;
        fire       = 1'b0;
        fire_cause = CAUSE_NONE;
        unique case (state)
            ST_RUN:     if (lp_entry) state_nx = deep_sel ? ST_STANDBY : ST_SLEEP;
            ST_SLEEP:   if (sleep_wake) begin
                            state_nx = ST_RUN; fire = 1'b1; fire_cause = sleep_cause;
                        end
            ST_STANDBY: if (nmi_ok) state_nx = ST_WARMUP;
            ST_WARMUP:  if (wdt_ovf) begin
                            state_nx = ST_RUN; fire = 1'b1; fire_cause = CAUSE_NMI;
                        end
            ST_RSTHOLD: if (!rst_any) begin
                            state_nx = ST_RUN; fire = 1'b1; fire_cause = rst_cause_q;
                        end
            default:    state_nx = ST_RUN;
        endcase
        if (rst_any) begin
            state_nx   = ST_RSTHOLD;
            fire       = 1'b0;
            fire_cause = CAUSE_NONE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Reset cause capture; power-on is sticky over manual within a hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_cause_q <= CAUSE_NONE;
        else if (rst_any) begin
            if (state != ST_RSTHOLD) rst_cause_q <= por_req ? CAUSE_POR : CAUSE_MRST;
            else if (por_req)        rst_cause_q <= CAUSE_POR;
        end
    end

    // Registered exception pulse and peripheral initialization pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_req        <= 1'b0;
            exc_cause      <= CAUSE_NONE;
            per_init_pulse <= 1'b0;
        end else begin
            exc_req        <= fire;
            exc_cause      <= fire ? fire_cause : CAUSE_NONE;
            per_init_pulse <= (state_nx == ST_STANDBY) && (state == ST_RUN);
        end
    end

    // Clock enables decoded from the state.
    always_comb begin
        cpu_clk_en = (state == ST_RUN);
        per_clk_en = (state == ST_RUN) || (state == ST_SLEEP) || (state == ST_RSTHOLD);
        osc_en     = (state != ST_STANDBY);
        wdt_clk_en = (state != ST_STANDBY);
    end

    // R10: the exception pulse coincides with the CPU clock enable rising.
    assert_exc_on_cpu_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (cpu_clk_en && !$past(cpu_clk_en)));
    // R10: the pulse lasts one cycle.
    assert_exc_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req);
    // R10: no cause without a request.
    assert_cause_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (exc_cause == CAUSE_NONE));
    // R2: the initialization pulse lasts one cycle.
    assert_init_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        per_init_pulse |=> !per_init_pulse);
    // R4: in standby only an NMI edge or a reset moves the state.
    assert_standby_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY && !nmi_ok && !rst_any) |=> (state == ST_STANDBY));
    // R6: no NMI edge is accepted right after entry.
    assert_entry_blocks_nmi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lp_entry |=> !nmi_ok);
    // R7: watchdog overflow in warm-up releases the core with the NMI cause.
    assert_warmup_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARMUP && wdt_ovf && !rst_any) |=> (exc_req && exc_cause == CAUSE_NMI));
    // R8: a reset request keeps the CPU clock stopped.
    assert_reset_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_any |=> !cpu_clk_en);
endmodule

// File: rtl/lpm_seq_ctrl.sv
// Top of the low-power sequencer: NMI front end, sleep wake arbiter and the
// mode state machine. The analog oscillator and the register file are outside.
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int LVL_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int BLOCK_CYC   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_strobe,
    input  logic             deep_sel,
    input  logic             irq_valid,
    input  logic             irq_src_en,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] mask_level,
    input  logic             dma_addr_err,
    input  logic             nmi_pin,
    input  logic             nmi_rise_sel,
    input  logic             por_req,
    input  logic             mrst_req,
    input  logic             wdt_ovf,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             per_init_pulse,
    output logic             osc_en,
    output logic             wdt_clk_en,
    output logic             exc_req,
    output logic [2:0]       exc_cause
);
    logic               nmi_ok;
    logic               lp_entry;
    logic               sleep_wake;
    logic [CAUSE_W-1:0] sleep_cause;

    lpm_nmi_detect #(.SYNC_STAGES(SYNC_STAGES), .BLOCK_CYC(BLOCK_CYC)) u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .rise_sel(nmi_rise_sel),
        .block_start(lp_entry), .nmi_ok(nmi_ok)
    );

    lpm_wake_arb #(.LVL_W(LVL_W)) u_arb (
        .nmi_ok(nmi_ok), .dma_err(dma_addr_err), .irq_valid(irq_valid),
        .irq_src_en(irq_src_en), .irq_level(irq_level), .mask_level(mask_level),
        .wake(sleep_wake), .cause(sleep_cause)
    );

    lpm_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .deep_sel(deep_sel),
        .por_req(por_req), .mrst_req(mrst_req), .nmi_ok(nmi_ok),
        .sleep_wake(sleep_wake), .sleep_cause(sleep_cause), .wdt_ovf(wdt_ovf),
        .lp_entry(lp_entry), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .per_init_pulse(per_init_pulse), .osc_en(osc_en), .wdt_clk_en(wdt_clk_en),
        .exc_req(exc_req), .exc_cause(exc_cause)
    );
endmodule

// File: tb/test_lpm_seq_ctrl.sv
module test_lpm_seq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n = 1'b0, sleep_strobe = 1'b0, deep_sel = 1'b0;
    logic irq_valid = 1'b0, irq_src_en = 1'b0;
    logic [3:0] irq_level = 4'd0, mask_level = 4'd3;
    logic dma_addr_err = 1'b0, nmi_pin = 1'b0, nmi_rise_sel = 1'b1;
    logic por_req = 1'b0, mrst_req = 1'b0, wdt_ovf = 1'b0;
    logic cpu_clk_en, per_clk_en, per_init_pulse, osc_en, wdt_clk_en, exc_req;
    logic [2:0] exc_cause;

    lpm_seq_ctrl i_lpm_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .deep_sel(deep_sel),
        .irq_valid(irq_valid), .irq_src_en(irq_src_en), .irq_level(irq_level),
        .mask_level(mask_level), .dma_addr_err(dma_addr_err), .nmi_pin(nmi_pin),
        .nmi_rise_sel(nmi_rise_sel), .por_req(por_req), .mrst_req(mrst_req),
        .wdt_ovf(wdt_ovf), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .per_init_pulse(per_init_pulse), .osc_en(osc_en), .wdt_clk_en(wdt_clk_en),
        .exc_req(exc_req), .exc_cause(exc_cause)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [2:0] exp_q[$];
    logic prev_cpu = 1'b1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_exc(input logic [2:0] c);
        exp_q.push_back(c);
    endtask

    task automatic enter(input logic deep);
        deep_sel = deep;
        sleep_strobe = 1'b1;
        step();
        sleep_strobe = 1'b0;
    endtask

    task automatic wait_run(output int n);
        n = 0;
        while (!cpu_clk_en && n < 20) begin
            step();
            n++;
        end
    endtask

    // Monitor: pops the expected cause for every exception pulse (R10).
    always @(negedge clk) begin
        if (!rst_n) prev_cpu = 1'b1;
        else begin
            if (exc_req) begin
                chk("R10 pulse with cpu enable rise", int'(cpu_clk_en && !prev_cpu), 1);
                if (exp_q.size() == 0) chk("R10 unexpected exception", 1, 0);
                else chk("R10 exception cause", int'(exc_cause), int'(exp_q.pop_front()));
            end else if (exc_cause != 3'd0) begin
                chk("R10 idle cause", int'(exc_cause), 0);
            end
            prev_cpu = cpu_clk_en;
        end
    end

    initial begin
        int n;
        step(5);
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 cpu_clk_en", cpu_clk_en, 1);
        chk("R11 per/osc/wdt", int'({per_clk_en, osc_en, wdt_clk_en}), 7);
        chk("R11 exc_req/init", int'({exc_req, per_init_pulse}), 0);

        // R1 sleep entry
        enter(1'b0);
        chk("R1 cpu off in sleep", cpu_clk_en, 0);
        chk("R1 per/osc on in sleep", int'({per_clk_en, osc_en}), 3);

        // R3 interrupt acceptance
        step(6);
        irq_valid = 1'b1; irq_src_en = 1'b1; irq_level = 4'd3;
        step(2);
        chk("R3 equal level ignored", cpu_clk_en, 0);
        irq_level = 4'd9; irq_src_en = 1'b0;
        step(2);
        chk("R3 disabled source ignored", cpu_clk_en, 0);
        expect_exc(3'd5);
        irq_src_en = 1'b1;
        step();
        chk("R3 accepted irq wakes", cpu_clk_en, 1);
        irq_valid = 1'b0;

        // R4 DMA error wakes sleep
        enter(1'b0);
        step(6);
        expect_exc(3'd4);
        dma_addr_err = 1'b1;
        step();
        chk("R4 dma wakes sleep", cpu_clk_en, 1);
        dma_addr_err = 1'b0;

        // R9 NMI beats DMA and IRQ
        enter(1'b0);
        step(6);
        expect_exc(3'd3);
        nmi_pin = 1'b1;
        step(2);
        dma_addr_err = 1'b1; irq_valid = 1'b1;
        step();
        chk("R9 wake with NMI first", cpu_clk_en, 1);
        dma_addr_err = 1'b0; irq_valid = 1'b0;
        // R9 DMA beats IRQ
        enter(1'b0);
        step(6);
        expect_exc(3'd4);
        dma_addr_err = 1'b1; irq_valid = 1'b1;
        step();
        chk("R9 wake with DMA over IRQ", cpu_clk_en, 1);
        dma_addr_err = 1'b0; irq_valid = 1'b0;

        // R5 falling edge select
        nmi_pin = 1'b0;
        nmi_rise_sel = 1'b0;
        step(3);
        enter(1'b0);
        step(6);
        nmi_pin = 1'b1;
        step(5);
        chk("R5 rising ignored with falling select", cpu_clk_en, 0);
        expect_exc(3'd3);
        nmi_pin = 1'b0;
        wait_run(n);
        chk("R5 falling edge wake latency", n, 3);
        nmi_rise_sel = 1'b1;
        step(3);

        // R2 standby entry
        enter(1'b1);
        chk("R2 all clocks off", int'({cpu_clk_en, per_clk_en, osc_en, wdt_clk_en}), 0);
        chk("R2 init pulse", per_init_pulse, 1);
        nmi_pin = 1'b1;  // edge lands inside the blocking window
        step();
        chk("R2 init pulse one cycle", per_init_pulse, 0);
        step(10);
        chk("R6 blocked edge discarded", osc_en, 0);
        dma_addr_err = 1'b1; irq_valid = 1'b1; irq_level = 4'd9;
        step(4);
        chk("R4 standby ignores dma/irq", int'({cpu_clk_en, osc_en}), 0);
        dma_addr_err = 1'b0; irq_valid = 1'b0;
        nmi_pin = 1'b0;
        step(4);
        chk("R5 opposite edge ignored", osc_en, 0);
        nmi_pin = 1'b1;
        step(3);
        chk("R7 warm-up osc/wdt on", int'({osc_en, wdt_clk_en}), 3);
        chk("R7 warm-up cpu/per off", int'({cpu_clk_en, per_clk_en}), 0);
        step(3);
        chk("R7 waits for watchdog", cpu_clk_en, 0);
        expect_exc(3'd3);
        wdt_ovf = 1'b1;
        step();
        wdt_ovf = 1'b0;
        chk("R7 chip ungated", int'({cpu_clk_en, per_clk_en, osc_en}), 7);

        // R8 resets
        enter(1'b0);
        por_req = 1'b1; mrst_req = 1'b1;
        step();
        chk("R8 hold cpu off", cpu_clk_en, 0);
        por_req = 1'b0;
        step(2);
        chk("R8 manual still holding", cpu_clk_en, 0);
        expect_exc(3'd1);
        mrst_req = 1'b0;
        step();
        chk("R8 release after por", cpu_clk_en, 1);
        enter(1'b1);
        mrst_req = 1'b1;
        step(2);
        chk("R8 manual holds from standby", cpu_clk_en, 0);
        expect_exc(3'd2);
        mrst_req = 1'b0;
        step();
        chk("R8 release after manual", cpu_clk_en, 1);
        por_req = 1'b1;
        step();
        chk("R8 por from run", cpu_clk_en, 0);
        expect_exc(3'd1);
        por_req = 1'b0;
        step();
        chk("R8 run after por", cpu_clk_en, 1);

        step(5);
        chk("R10 all expected exceptions seen", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule